// File: doc/BRIEF.md
# Multi-Source Reset Supervisor with Selectable Release Delay

This block drives an active-low system reset for a board or subsystem. It merges four kinds of hold-off: a power-good flag for each supply rail, a flag saying the analog enable is above its threshold, an active-low shutdown request, and an active-low shared fault line. While any of these is present, the reset output is low. The output follows a new hold-off with no clock edge in the path, so a power-down that starts from shutdown or enable pulls reset at once, before any rail has started to fall.

Release is timed by a counter on a free-running clock. The count starts when every hold-off is clear. Reset is released only after the count runs for the selected number of cycles without a break. A hold-off that returns during the count clears it. A two-bit mode input picks the release delay: a short default (nominally 10 µs), a long fixed period (nominally 128 ms), or the short base plus a programmable extra cycle count. All lengths are cycle-count parameters, so a small configuration can be used in simulation.

Top module: `rstsup_top`

## Requirements
- R1: Whenever any bit of `rail_good` is 0, `sys_rst_n` is 0 in the same cycle, with no clock edge needed.
- R2: Whenever `en_ok` is 0, `sys_rst_n` is 0 in the same cycle.
- R3: Whenever `shdn_n` is 0, `sys_rst_n` is 0 in the same cycle.
- R4: Whenever `fault_n` is 0, `sys_rst_n` is 0 in the same cycle.
- R5: While `por_n` is low, `sys_rst_n` is 0. After `por_n` rises, `sys_rst_n` stays 0 until the first full release delay has passed with all hold-offs clear.
- R6: `sys_rst_n` rises just after the T-th rising clock edge at which all hold-offs are clear, counting only an unbroken run of such edges. T is the delay chosen by the mode.
- R7: `tmo_mode` = 2'b00 selects T = SHORT_CYC, and `tmo_extra` has no effect.
- R8: `tmo_mode` = 2'b01 selects T = LONG_CYC, and `tmo_extra` has no effect.
- R9: `tmo_mode` = 2'b10 selects T = SHORT_CYC + `tmo_extra`, read as an unsigned value. With an extra of 0 this gives SHORT_CYC.
- R10: `tmo_mode` = 2'b11 behaves exactly like 2'b00.
- R11: If a hold-off appears at any clock edge during the count, the count returns to zero. Once all hold-offs clear again, a full T is needed before release.
- R12: Once released, `sys_rst_n` stays 1 for as long as no hold-off is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| por_n | input | 1 | Asynchronous power-on reset of the supervisor's own state, active low |
| rail_good | input | NUM_RAILS | Power-good flag for each rail; 1 = above threshold |
| en_ok | input | 1 | Analog enable above its threshold |
| shdn_n | input | 1 | Shutdown request, active low |
| fault_n | input | 1 | Shared fault line, active low |
| tmo_mode | input | 2 | Release delay select: 00 short, 01 long, 10 short + extra, 11 short |
| tmo_extra | input | EXTRA_W | Extra cycles added in programmable mode |
| sys_rst_n | output | 1 | System reset output, active low |

## Verification
The release delay is measured edge by edge for every mode code. Mode 2'b10 is swept through every extra value, which separates an off-by-one in the base from an error in how the extra is added. Mode 2'b00 and mode 2'b11 are run with nonzero extras, which shows the extra is ignored there. Each hold-off source is pulsed alone, with its own rail index, and the output is checked before the next clock edge; this separates a combinational assert path from a registered one. A short pulse placed in the middle of a long count shows whether the count really restarts or only pauses.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  typedef enum logic [1:0] {
    TMO_SHORT = 2'b00,
    TMO_LONG  = 2'b01,
    TMO_PROG  = 2'b10,
    TMO_ALT   = 2'b11
  } tmo_mode_e;

  // Largest release delay any mode can request.
  function automatic int unsigned tmo_max(input int unsigned short_cyc,
                                          input int unsigned long_cyc,
                                          input int unsigned extra_w);
    int unsigned prog_max;
    prog_max = short_cyc + ((32'd1 << extra_w) - 32'd1);
    return (long_cyc > prog_max) ? long_cyc : prog_max;
  endfunction

  // Release delay in cycles for a given mode and extra value.
  function automatic int unsigned tmo_cycles(input tmo_mode_e mode,
                                             input int unsigned extra,
                                             input int unsigned short_cyc,
                                             input int unsigned long_cyc);
    case (mode)
      TMO_LONG: return long_cyc;
      TMO_PROG: return short_cyc + extra;
      default:  return short_cyc;
    endcase
  endfunction

endpackage

// File: rtl/rstsup_holdoff.sv
module rstsup_holdoff #(
  parameter int unsigned NUM_RAILS = 4
) (
  input  logic [NUM_RAILS-1:0] rail_good,
  input  logic                 en_ok,
  input  logic                 shdn_n,
  input  logic                 fault_n,
  output logic [3:0]           hold_src,
  output logic                 hold_any
);
  logic [NUM_RAILS-1:0] rail_low;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    assign rail_low[g] = ~rail_good[g];
  end

  assign hold_src[0] = |rail_low;
  assign hold_src[1] = ~en_ok;
  assign hold_src[2] = ~shdn_n;
  assign hold_src[3] = ~fault_n;
  assign hold_any    = |hold_src;
endmodule

// File: rtl/rstsup_timer.sv
module rstsup_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          hold,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] elapsed,
  output logic          expire,
  output logic          released
);
  logic [CW-1:0] cnt_q;
  logic          rel_q;

  // Fires on the edge that completes the limit-th clear cycle.
  assign expire = ~hold & ~rel_q & (cnt_q >= limit - CW'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (hold) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (expire) rel_q <= 1'b1;
      else        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign elapsed  = cnt_q;
  assign released = rel_q;
endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
  import rstsup_pkg::*;
#(
  parameter int unsigned NUM_RAILS = 4,
  parameter int unsigned SHORT_CYC = 1000,
  parameter int unsigned LONG_CYC  = 12800000,
  parameter int unsigned EXTRA_W   = 16
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic [NUM_RAILS-1:0] rail_good,
  input  logic                 en_ok,
  input  logic                 shdn_n,
  input  logic                 fault_n,
  input  logic [1:0]           tmo_mode,
  input  logic [EXTRA_W-1:0]   tmo_extra,
  output logic                 sys_rst_n
);
  localparam int unsigned MAXT = tmo_max(SHORT_CYC, LONG_CYC, EXTRA_W);
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [3:0]    hold_src;
  logic          hold_any;
  logic [CW-1:0] limit;
  logic [CW-1:0] elapsed;
  logic          tmo_expire;
  logic          released;

  rstsup_holdoff #(.NUM_RAILS(NUM_RAILS)) u_hold (
    .rail_good (rail_good),
    .en_ok     (en_ok),
    .shdn_n    (shdn_n),
    .fault_n   (fault_n),
    .hold_src  (hold_src),
    .hold_any  (hold_any)
  );

  assign limit = CW'(tmo_cycles(tmo_mode_e'(tmo_mode), 32'(tmo_extra),
                                SHORT_CYC, LONG_CYC));

  rstsup_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .por_n    (por_n),
    .hold     (hold_any),
    .limit    (limit),
    .elapsed  (elapsed),
    .expire   (tmo_expire),
    .released (released)
  );

  // Assertion path has no flop: any hold-off forces reset at once.
  assign sys_rst_n = released & ~hold_any;
endmodule

// File: rtl/rstsup_chk.sv
module rstsup_chk #(
  parameter int unsigned NUM_RAILS = 4,
  parameter int unsigned CW        = 8,
  parameter int unsigned MAXT      = 100
) (
  input logic                 clk,
  input logic                 por_n,
  input logic [NUM_RAILS-1:0] rail_good,
  input logic                 en_ok,
  input logic                 shdn_n,
  input logic                 fault_n,
  input logic                 sys_rst_n,
  input logic [CW-1:0]        elapsed,
  input logic                 tmo_expire
);
  logic any_cond;
  assign any_cond = ~(&rail_good) | ~en_ok | ~shdn_n | ~fault_n;

  // Covers R2, R3 and R4 as well, since any_cond includes every source.
  assert_holdoff_forces_reset_R1: assert property (@(posedge clk) disable iff (!por_n)
    any_cond |-> !sys_rst_n);

  assert_release_after_expiry_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> $past(tmo_expire));

  assert_count_restarts_R11: assert property (@(posedge clk) disable iff (!por_n)
    any_cond |=> (elapsed == '0));

  assert_release_sticks_R12: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_n |=> (sys_rst_n || any_cond));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!por_n)
    32'(elapsed) <= MAXT);
endmodule

bind rstsup_top rstsup_chk #(
  .NUM_RAILS (NUM_RAILS),
  .CW        (CW),
  .MAXT      (MAXT)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rail_good  (rail_good),
  .en_ok      (en_ok),
  .shdn_n     (shdn_n),
  .fault_n    (fault_n),
  .sys_rst_n  (sys_rst_n),
  .elapsed    (elapsed),
  .tmo_expire (tmo_expire)
);

// File: tb/sim_rstsup_top.sv
module sim_rstsup_top;
  localparam int PERIOD = 10;
  localparam int NR     = 3;
  localparam int SHORT  = 4;
  localparam int LONG   = 40;
  localparam int EW     = 3;

  logic          clk = 1'b0;
  logic          por_n;
  logic [NR-1:0] rail_good;
  logic          en_ok, shdn_n, fault_n;
  logic [1:0]    tmo_mode;
  logic [EW-1:0] tmo_extra;
  logic          sys_rst_n;

  int total = 0;
  int bad   = 0;
  bit over  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  rstsup_top #(.NUM_RAILS(NR), .SHORT_CYC(SHORT), .LONG_CYC(LONG), .EXTRA_W(EW)) u0 (
    .clk(clk), .por_n(por_n), .rail_good(rail_good), .en_ok(en_ok),
    .shdn_n(shdn_n), .fault_n(fault_n), .tmo_mode(tmo_mode),
    .tmo_extra(tmo_extra), .sys_rst_n(sys_rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_delay(input int m, input int e);
    if (m == 1) return LONG;
    if (m == 2) return SHORT + e;
    return SHORT;
  endfunction

  // Count clock edges from now until the reset releases (0 if it never does).
  task automatic measure(output int n);
    n = 0;
    for (int i = 1; i <= 3*LONG; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (sys_rst_n) begin
        n = i;
        break;
      end
    end
  endtask

  // src: 0..NR-1 rail, NR enable, NR+1 shutdown, NR+2 fault
  task automatic pulse(input int src, input string req);
    @(negedge clk);
    if (src < NR)       rail_good[src] = 1'b0;
    else if (src == NR) en_ok = 1'b0;
    else if (src == NR+1) shdn_n = 1'b0;
    else                fault_n = 1'b0;
    #1;
    chk(sys_rst_n == 1'b0, req, int'(sys_rst_n), 0);
    @(negedge clk);
    rail_good = '1; en_ok = 1'b1; shdn_n = 1'b1; fault_n = 1'b1;
  endtask

  initial begin
    int n;
    por_n = 1'b0; rail_good = '1; en_ok = 1'b1; shdn_n = 1'b1; fault_n = 1'b1;
    tmo_mode = 2'b00; tmo_extra = '0;
    repeat (3) @(negedge clk);
    chk(sys_rst_n == 1'b0, "R5 reset during por", int'(sys_rst_n), 0);
    por_n = 1'b1;
    measure(n);
    chk(n == SHORT, "R5 first release after por", n, SHORT);

    // Every mode; extra swept fully in programmable mode, nonzero elsewhere.
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < (1 << EW); e++) begin
        if (m != 2 && e != 0 && e != 5) continue;
        tmo_mode = 2'(m); tmo_extra = EW'(e);
        pulse(NR+2, "R4 fault asserts");
        measure(n);
        case (m)
          0: chk(n == exp_delay(m, e), "R7 short mode delay", n, exp_delay(m, e));
          1: chk(n == exp_delay(m, e), "R8 long mode delay", n, exp_delay(m, e));
          2: chk(n == exp_delay(m, e), "R9 programmable delay", n, exp_delay(m, e));
          default: chk(n == exp_delay(m, e), "R10 alt code delay", n, exp_delay(m, e));
        endcase
      end
    end

    // Each source alone.
    tmo_mode = 2'b00; tmo_extra = '0;
    for (int r = 0; r < NR; r++) begin
      pulse(r, "R1 rail low asserts");
      measure(n);
      chk(n == SHORT, "R6 delay after rail", n, SHORT);
    end
    pulse(NR, "R2 enable low asserts");
    measure(n);
    chk(n == SHORT, "R6 delay after enable", n, SHORT);
    pulse(NR+1, "R3 shutdown asserts");
    measure(n);
    chk(n == SHORT, "R6 delay after shutdown", n, SHORT);

    // Restart of the count mid-way.
    tmo_mode = 2'b10; tmo_extra = 3'd7;
    pulse(NR+2, "R4 fault asserts");
    repeat (8) @(negedge clk);
    chk(sys_rst_n == 1'b0, "R11 still counting", int'(sys_rst_n), 0);
    pulse(1, "R1 rail low mid-count");
    measure(n);
    chk(n == SHORT + 7, "R11 full delay after restart", n, SHORT + 7);

    // Stays released.
    repeat (20) @(negedge clk);
    chk(sys_rst_n == 1'b1, "R12 stays released", int'(sys_rst_n), 1);

    over = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!over) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule